// File: doc/BRIEF.md
# Store-Intent Cache Line Touch Unit

This unit carries out a cache touch instruction for an in-order core's data path. It takes one instruction word at a time with its two register operands. It checks that the word is a touch, and it forms the effective address from an optional base plus an index. It then sends that address to an external translator. If the page is cacheable and the translation is clean, it asks the tag store whether the line is already present. On a miss it issues a line-aligned fill request to the memory side and holds it until the request is acknowledged. Every path ends with a single-cycle done strobe.

A touch is only a hint. Hits, caching-inhibited pages, translation faults and translation misses all finish quietly, with no fill, no exception and no architectural register write. The access counts as a read for permission checks. The store-intent and load-intent opcodes take exactly the same path. A malformed word is flagged at completion and starts no work.

Instructions arrive on a valid/ready pair. The `in_ready` signal is high only while the unit is idle, and a word is taken on a clock edge where `in_valid` and `in_ready` are both high. The `in_valid` signal may stay high while `in_ready` is low, and nothing is taken during that time. The fill request behaves as a valid signal whose ready is `fill_ack`. Once raised, it stays high with an unchanging address until it is acknowledged.

Top module: `touch_prefetch_unit`

## Requirements
- R1: Bits are numbered with bit 0 as the most significant bit, so bit k is `in_insn[31-k]`. A word is a touch when bits 0–5 hold 31 and bits 21–30 hold 246 (store intent) or 278 (load intent). The base selector field is bits 11–15, and the index register comes from `in_rb_val`.
- R2: One cycle after acceptance, `xlat_req` is high and `xlat_addr` equals `in_rb_val` plus a base. The base is zero when the selector field is 0, and `in_ra_val` otherwise. The sum wraps modulo 2^AW.
- R3: If translation is clean, the page is cacheable and the tag lookup misses, `fill_req` rises in the cycle after the tag response. `fill_addr` equals the translated address with its low log2(LINE_BYTES) bits cleared. `tag_addr` carries the same aligned value.
- R4: A tag hit ends the instruction with `done` in the cycle after the tag response, and no fill is requested.
- R5: A translation fault or a translation miss ends the instruction with `done` in the cycle after the response, with no tag lookup and no fill. `exc_raise` stays 0 at all times.
- R6: A caching-inhibited page ends the instruction with `done` in the cycle after the response, with no tag lookup and no fill.
- R7: `xlat_is_store` is 0 at all times, so the translator checks read permission only.
- R8: Bit 31 of the word has no effect on the outcome. `cr_we` and `gpr_we` stay 0 at all times.
- R9: The store-intent form (246) and the load-intent form (278) give identical addresses, requests and outcomes.
- R10: `in_ready` is low from the cycle after acceptance until the cycle after `done`. `done` lasts exactly one cycle. `fill_req` and `fill_addr` hold steady until `fill_ack`.
- R11: A word with a nonzero value in bits 6–10, or with an unrecognised opcode, raises `done` together with `done_invalid` in the cycle after acceptance, with no translation request and no fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, can take an instruction |
| in_insn | input | 32 | Instruction word |
| in_ra_val | input | AW | Base register value |
| in_rb_val | input | AW | Index register value |
| xlat_req | output | 1 | Translation request pending |
| xlat_addr | output | AW | Effective address to translate |
| xlat_is_store | output | 1 | Access kind for permission checks (always read) |
| xlat_rsp_valid | input | 1 | Translation response present |
| xlat_fault | input | 1 | Storage permission fault |
| xlat_tlb_miss | input | 1 | No translation entry found |
| xlat_inhibit | input | 1 | Page is caching-inhibited |
| xlat_paddr | input | AW | Translated address |
| tag_req | output | 1 | Tag lookup pending |
| tag_addr | output | AW | Line-aligned address to look up |
| tag_rsp_valid | input | 1 | Tag response present |
| tag_hit | input | 1 | Line present in the cache |
| fill_req | output | 1 | Line fill requested |
| fill_addr | output | AW | Line-aligned fill address |
| fill_ack | input | 1 | Fill request taken |
| done | output | 1 | One-cycle completion strobe |
| done_invalid | output | 1 | With done: the word was an invalid form |
| cr_we | output | 1 | Condition register write (always 0) |
| gpr_we | output | 1 | General register write (always 0) |
| exc_raise | output | 1 | Exception request (always 0) |

## Verification
Each result has its own due cycle. The translation request is due one cycle after acceptance, and an invalid form's `done` is due in the same cycle. Each response the stubs give (translation, tag, fill acknowledge) moves the unit on by exactly one cycle: either `done` or the next request appears in the cycle after the response. The bench drives a response after a chosen number of wait cycles and checks during those waits that nothing has moved on. It samples on the falling edge exactly one cycle after each response, and checks one cycle after `done` that the unit is idle again. It sweeps every combination of fault, translation miss, inhibit and hit across both opcodes, both values of bit 31, and several base selector values. It also sweeps every nonzero reserved value, and it compares the expected aligned addresses and fill counts, all computed arithmetically in the bench.

// File: rtl/touch_pkg.sv
package touch_pkg;
  localparam int unsigned INSN_W       = 32;
  localparam logic [5:0] PRIMARY_OP    = 6'd31;
  localparam logic [9:0] EXT_TOUCH_ST  = 10'd246;
  localparam logic [9:0] EXT_TOUCH_LD  = 10'd278;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XLAT,
    ST_LOOK,
    ST_FILL,
    ST_DONE
  } touch_state_e;

  typedef struct packed {
    logic       form_ok;
    logic       opcode_ok;
    logic       rsvd_zero;
    logic [4:0] base_sel;
    logic [4:0] index_sel;
  } touch_dec_t;
endpackage

// File: rtl/touch_decode.sv
module touch_decode
  import touch_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output touch_dec_t        dec_o
);
  logic [5:0] primary;
  logic [9:0] extended;
  logic [4:0] rsvd;
  logic       unused_rc;

  // big-endian bit k maps to insn_i[31-k]
  assign primary   = insn_i[31:26];
  assign rsvd      = insn_i[25:21];
  assign extended  = insn_i[10:1];
  assign unused_rc = insn_i[0];

  always_comb begin
    dec_o.base_sel  = insn_i[20:16];
    dec_o.index_sel = insn_i[15:11];
    dec_o.rsvd_zero = (rsvd == 5'd0);
    dec_o.opcode_ok = (primary == PRIMARY_OP) &&
                      ((extended == EXT_TOUCH_ST) || (extended == EXT_TOUCH_LD));
    dec_o.form_ok   = dec_o.opcode_ok && dec_o.rsvd_zero;
  end
endmodule

// File: rtl/touch_ea.sv
module touch_ea #(
  parameter int unsigned AW = 32
) (
  input  logic [4:0]    base_sel_i,
  input  logic [AW-1:0] ra_val_i,
  input  logic [AW-1:0] rb_val_i,
  output logic [AW-1:0] ea_o
);
  logic [AW-1:0] base;

  assign base = (base_sel_i == 5'd0) ? '0 : ra_val_i;
  assign ea_o = base + rb_val_i;
endmodule

// File: rtl/touch_align.sv
module touch_align #(
  parameter int unsigned AW         = 32,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] line_o
);
  localparam int unsigned OFF_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 0;

  generate
    if (OFF_W == 0) begin : g_byte_line
      assign line_o = addr_i;
    end else begin : g_wide_line
      logic unused_offset;
      assign unused_offset = ^addr_i[OFF_W-1:0];
      assign line_o = {addr_i[AW-1:OFF_W], {OFF_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/touch_ctrl.sv
module touch_ctrl
  import touch_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid_i,
  input  logic          form_ok_i,
  input  logic [AW-1:0] ea_i,
  output logic          in_ready_o,
  output logic          xlat_req_o,
  output logic [AW-1:0] xlat_addr_o,
  input  logic          xlat_rsp_valid_i,
  input  logic          xlat_fault_i,
  input  logic          xlat_tlb_miss_i,
  input  logic          xlat_inhibit_i,
  input  logic [AW-1:0] xlat_paddr_i,
  output logic          tag_req_o,
  output logic [AW-1:0] tag_addr_o,
  input  logic          tag_rsp_valid_i,
  input  logic          tag_hit_i,
  output logic          fill_req_o,
  output logic [AW-1:0] fill_addr_o,
  input  logic          fill_ack_i,
  output logic          done_o,
  output logic          done_invalid_o
);
  touch_state_e  state_q, state_d;
  logic [AW-1:0] ea_q;
  logic [AW-1:0] line_q;
  logic [AW-1:0] line_d;
  logic          invalid_q;
  logic          accept;
  logic          quiet_xlat;

  touch_align #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_align (
    .addr_i (xlat_paddr_i),
    .line_o (line_d)
  );

  assign accept     = in_valid_i && (state_q == ST_IDLE);
  assign quiet_xlat = xlat_fault_i || xlat_tlb_miss_i || xlat_inhibit_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (in_valid_i) state_d = form_ok_i ? ST_XLAT : ST_DONE;
      ST_XLAT: if (xlat_rsp_valid_i) state_d = quiet_xlat ? ST_DONE : ST_LOOK;
      ST_LOOK: if (tag_rsp_valid_i) state_d = tag_hit_i ? ST_DONE : ST_FILL;
      ST_FILL: if (fill_ack_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ea_q      <= '0;
      line_q    <= '0;
      invalid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ea_q      <= ea_i;
        invalid_q <= !form_ok_i;
      end
      if (state_q == ST_XLAT && xlat_rsp_valid_i) line_q <= line_d;
    end
  end

  assign in_ready_o     = (state_q == ST_IDLE);
  assign xlat_req_o     = (state_q == ST_XLAT);
  assign xlat_addr_o    = ea_q;
  assign tag_req_o      = (state_q == ST_LOOK);
  assign tag_addr_o     = line_q;
  assign fill_req_o     = (state_q == ST_FILL);
  assign fill_addr_o    = line_q;
  assign done_o         = (state_q == ST_DONE);
  assign done_invalid_o = done_o && invalid_q;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o && in_valid_i |=> !in_ready_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && in_ready_o); // R10
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_o && !fill_ack_i |=> fill_req_o && $stable(fill_addr_o)); // R10
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tag_req_o && tag_rsp_valid_i && tag_hit_i |=> done_o && !fill_req_o); // R4
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req_o && xlat_rsp_valid_i && (xlat_fault_i || xlat_tlb_miss_i)
      |=> done_o && !tag_req_o && !fill_req_o); // R5
  AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req_o && xlat_rsp_valid_i && xlat_inhibit_i
      |=> done_o && !tag_req_o); // R6
endmodule

// File: rtl/touch_prefetch_unit.sv
module touch_prefetch_unit
  import touch_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [AW-1:0]     in_ra_val,
  input  logic [AW-1:0]     in_rb_val,
  output logic              xlat_req,
  output logic [AW-1:0]     xlat_addr,
  output logic              xlat_is_store,
  input  logic              xlat_rsp_valid,
  input  logic              xlat_fault,
  input  logic              xlat_tlb_miss,
  input  logic              xlat_inhibit,
  input  logic [AW-1:0]     xlat_paddr,
  output logic              tag_req,
  output logic [AW-1:0]     tag_addr,
  input  logic              tag_rsp_valid,
  input  logic              tag_hit,
  output logic              fill_req,
  output logic [AW-1:0]     fill_addr,
  input  logic              fill_ack,
  output logic              done,
  output logic              done_invalid,
  output logic              cr_we,
  output logic              gpr_we,
  output logic              exc_raise
);
  touch_dec_t    dec;
  logic [AW-1:0] ea;
  logic [4:0]    unused_index_sel;

  touch_decode u_decode (
    .insn_i (in_insn),
    .dec_o  (dec)
  );

  assign unused_index_sel = dec.index_sel;

  touch_ea #(.AW(AW)) u_ea (
    .base_sel_i (dec.base_sel),
    .ra_val_i   (in_ra_val),
    .rb_val_i   (in_rb_val),
    .ea_o       (ea)
  );

  touch_ctrl #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_valid_i       (in_valid),
    .form_ok_i        (dec.form_ok),
    .ea_i             (ea),
    .in_ready_o       (in_ready),
    .xlat_req_o       (xlat_req),
    .xlat_addr_o      (xlat_addr),
    .xlat_rsp_valid_i (xlat_rsp_valid),
    .xlat_fault_i     (xlat_fault),
    .xlat_tlb_miss_i  (xlat_tlb_miss),
    .xlat_inhibit_i   (xlat_inhibit),
    .xlat_paddr_i     (xlat_paddr),
    .tag_req_o        (tag_req),
    .tag_addr_o       (tag_addr),
    .tag_rsp_valid_i  (tag_rsp_valid),
    .tag_hit_i        (tag_hit),
    .fill_req_o       (fill_req),
    .fill_addr_o      (fill_addr),
    .fill_ack_i       (fill_ack),
    .done_o           (done),
    .done_invalid_o   (done_invalid)
  );

  // a touch is a hint: read-class access, never architecturally visible
  assign xlat_is_store = 1'b0;
  assign cr_we         = 1'b0;
  assign gpr_we        = 1'b0;
  assign exc_raise     = 1'b0;

  AST_BAD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !dec.form_ok |=> done && done_invalid && !xlat_req); // R11
  AST_GOOD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && dec.form_ok |=> xlat_req && !done); // R1
  AST_MISS_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    tag_req && tag_rsp_valid && !tag_hit |=> fill_req && fill_addr == $past(tag_addr)); // R3
endmodule

// File: tb/touch_prefetch_unit_bench.sv
module touch_prefetch_unit_bench;
  localparam int unsigned AW = 32;
  localparam int unsigned LB = 32;
  localparam logic [AW-1:0] LMASK = ~(AW'(LB) - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_insn = '0;
  logic [AW-1:0] in_ra_val = '0, in_rb_val = '0;
  logic xlat_req, xlat_is_store;
  logic [AW-1:0] xlat_addr;
  logic xlat_rsp_valid = 1'b0, xlat_fault = 1'b0, xlat_tlb_miss = 1'b0, xlat_inhibit = 1'b0;
  logic [AW-1:0] xlat_paddr = '0;
  logic tag_req, tag_rsp_valid = 1'b0, tag_hit = 1'b0;
  logic [AW-1:0] tag_addr, fill_addr;
  logic fill_req, fill_ack = 1'b0;
  logic done, done_invalid, cr_we, gpr_we, exc_raise;

  int checks = 0, errors = 0;
  int fills_seen = 0, fills_exp = 0;
  int store_flag_cycles = 0, reg_write_cycles = 0, exc_cycles = 0;

  always #10 clk = ~clk;

  touch_prefetch_unit #(.AW(AW), .LINE_BYTES(LB)) u_touch_prefetch_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_ra_val(in_ra_val), .in_rb_val(in_rb_val),
    .xlat_req(xlat_req), .xlat_addr(xlat_addr), .xlat_is_store(xlat_is_store),
    .xlat_rsp_valid(xlat_rsp_valid), .xlat_fault(xlat_fault),
    .xlat_tlb_miss(xlat_tlb_miss), .xlat_inhibit(xlat_inhibit), .xlat_paddr(xlat_paddr),
    .tag_req(tag_req), .tag_addr(tag_addr), .tag_rsp_valid(tag_rsp_valid), .tag_hit(tag_hit),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_ack(fill_ack),
    .done(done), .done_invalid(done_invalid), .cr_we(cr_we), .gpr_we(gpr_we),
    .exc_raise(exc_raise)
  );

  always @(posedge clk) if (rst_n) begin
    if (fill_req && fill_ack) fills_seen++;
    if (xlat_is_store) store_flag_cycles++;
    if (cr_we || gpr_we) reg_write_cycles++;
    if (exc_raise) exc_cycles++;
  end

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input int ext, input int rsvd, input int raf, input int rbf, input bit rc);
    return {6'd31, 5'(rsvd), 5'(raf), 5'(rbf), 10'(ext), rc};
  endfunction

  task automatic run(input logic [31:0] insn, input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                     input logic [AW-1:0] pa, input bit flt, input bit tmiss, input bit inh,
                     input bit hit, input int lat, input bit expect_bad);
    logic [AW-1:0] ea_exp;
    ea_exp = ((insn[20:16] == 5'd0) ? '0 : ra) + rb;
    @(negedge clk);
    chk(in_ready, "R10 idle before issue", AW'(in_ready), 1);
    in_valid = 1'b1; in_insn = insn; in_ra_val = ra; in_rb_val = rb;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R10 busy after accept", AW'(in_ready), 0);
    if (expect_bad) begin
      chk(done && done_invalid && !xlat_req, "R11 invalid form ends at once",
          AW'({done, done_invalid, xlat_req}), AW'(3'b110));
    end else begin
      chk(xlat_req && !done && xlat_addr == ea_exp, "R2 effective address", xlat_addr, ea_exp);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(xlat_req && !done, "R10 waits for translation", AW'(done), 0);
      end
      xlat_rsp_valid = 1'b1; xlat_fault = flt; xlat_tlb_miss = tmiss;
      xlat_inhibit = inh; xlat_paddr = pa;
      @(negedge clk);
      xlat_rsp_valid = 1'b0; xlat_fault = 1'b0; xlat_tlb_miss = 1'b0; xlat_inhibit = 1'b0;
      if (flt || tmiss || inh) begin
        chk(done && !done_invalid && !tag_req && !fill_req,
            (flt || tmiss) ? "R5 fault no-op" : "R6 inhibited no-op",
            AW'({done, tag_req, fill_req}), AW'(3'b100));
      end else begin
        chk(tag_req && tag_addr == (pa & LMASK), "R3 lookup aligned", tag_addr, pa & LMASK);
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(tag_req && !done, "R10 waits for tag", AW'(done), 0);
        end
        tag_rsp_valid = 1'b1; tag_hit = hit;
        @(negedge clk);
        tag_rsp_valid = 1'b0; tag_hit = 1'b0;
        if (hit) begin
          chk(done && !fill_req, "R4 hit no-op", AW'({done, fill_req}), AW'(2'b10));
        end else begin
          fills_exp++;
          chk(fill_req && !done && fill_addr == (pa & LMASK), "R3 fill address", fill_addr, pa & LMASK);
          for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(fill_req && fill_addr == (pa & LMASK) && !done, "R10 fill held", fill_addr, pa & LMASK);
          end
          fill_ack = 1'b1;
          @(negedge clk);
          fill_ack = 1'b0;
          chk(done && !fill_req, "R10 done after ack", AW'({done, fill_req}), AW'(2'b10));
        end
      end
    end
    @(negedge clk);
    chk(in_ready && !done, "R10 done single cycle", AW'({in_ready, done}), AW'(2'b10));
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rafs[4];
    rafs = '{0, 1, 7, 31};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !xlat_req && !tag_req && !fill_req && !done, "R10 reset state",
        AW'({in_ready, xlat_req, tag_req, fill_req, done}), AW'(5'b10000));
    // R1 R9 R8: both opcodes, both Rc values, every outcome mix
    foreach (rafs[k]) for (int op = 0; op < 2; op++) for (int rc = 0; rc < 2; rc++)
      for (int f = 0; f < 16; f++) begin
        logic [AW-1:0] ra, rb, pa;
        ra = 32'hFFFF_F000 + AW'(rafs[k] * 32'h111) + AW'(f);
        rb = AW'(f * 32'h35 + rc * 32'h9) + AW'(op * 32'h1000);
        pa = (ra + rb) ^ 32'h4000_0000 ^ AW'(f << 3);
        run(mk(op ? 278 : 246, 0, rafs[k], f, rc[0]), ra, rb, pa,
            f[0], f[1], f[2], f[3], (f + k) % 3, 1'b0);
      end
    // R11: every nonzero reserved value
    for (int r = 1; r < 32; r++)
      run(mk(246, r, 3, 4, 1'b0), 32'h100, 32'h20, 32'h0, 0, 0, 0, 0, 0, 1'b1);
    run({6'd30, 5'd0, 5'd3, 5'd4, 10'd246, 1'b0}, 32'h100, 32'h20, 0, 0, 0, 0, 0, 0, 1'b1); // R11
    run(mk(86, 0, 3, 4, 1'b0), 32'h100, 32'h20, 0, 0, 0, 0, 0, 0, 1'b1); // R11
    // R2 wraparound
    run(mk(278, 0, 5, 6, 1'b1), 32'hFFFF_FFF0, 32'h0000_0031, 32'h1234_5677, 0, 0, 0, 0, 1, 1'b0);
    repeat (2) @(negedge clk);
    chk(fills_seen == fills_exp, "R3 fill count", AW'(fills_seen), AW'(fills_exp));
    chk(store_flag_cycles == 0, "R7 read-class access", AW'(store_flag_cycles), 0);
    chk(reg_write_cycles == 0, "R8 no register writes", AW'(reg_write_cycles), 0);
    chk(exc_cycles == 0, "R5 no exception", AW'(exc_cycles), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule